// File: doc/BRIEF.md
# Double-Indirection Effective Address Generator

This block forms the operand address for a CPU addressing unit that can follow a pointer held in memory. It takes an already selected base register value, a base displacement, an index register value with a scale selector, and an outer displacement. The register file and the decoding of extension words are outside the block; their results arrive here as plain values together with suppress and size flags.

In the plain indexed mode the address is the sum of base, displacement and scaled index, and the result is ready the cycle after the start strobe. In the two indirect modes the block first reads a 32-bit pointer from memory through a request/ready port. It then adds the outer displacement to the fetched pointer. The scaled index is added either before the read (it joins the read address) or after it (it joins the fetched pointer). A one-cycle done strobe marks the result, and a start that arrives while the block is working has no effect.

Top module: `ea_indirect_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `done`, `mem_req` and `busy` are 0.
- R2: For mode codes 0 and 3 (non-indirect), a start yields `ea` = base + base displacement + scaled index, with `done` high exactly one cycle after the start edge and `mem_req` never raised.
- R3: The 2-bit scale field multiplies the index by 1, 2, 4 or 8 for codes 0, 1, 2 and 3 (a left shift by the code).
- R4: A displacement with its long flag at 0 uses its low 16 bits sign-extended to 32 bits; with the flag at 1 it uses all 32 bits. This holds for both the base and the outer displacement.
- R5: Mode code 1 (pre-indexed) reads from base + base displacement + scaled index, and `ea` = fetched pointer + outer displacement.
- R6: Mode code 2 (post-indexed) reads from base + base displacement, and `ea` = fetched pointer + scaled index + outer displacement.
- R7: The base suppress flag replaces the base by zero and the index suppress flag replaces the scaled index by zero, in every mode.
- R8: In indirect modes `mem_req` rises two cycles after the start edge, stays high with `mem_addr` unchanged until `mem_rdy` is sampled high, and `done` follows on the next cycle, so `done` is due 3 + W cycles after the start edge for W wait cycles.
- R9: A start asserted while `busy` is high, with any operands, changes neither the result nor its timing, and produces no second `done`.
- R10: `done` is high for a single cycle, and the block returns to idle (`busy` low) on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| mode | input | 2 | 0/3 indexed, 1 pre-indexed indirect, 2 post-indexed indirect |
| base_val | input | 32 | Selected base register value |
| base_sup | input | 1 | Use zero instead of the base |
| base_disp | input | 32 | Base displacement |
| bdisp_long | input | 1 | 1: full 32-bit base displacement, 0: sign-extended low 16 bits |
| idx_val | input | 32 | Selected index register value |
| idx_sup | input | 1 | Use zero instead of the scaled index |
| scale | input | 2 | Index shift amount (×1, ×2, ×4, ×8) |
| outer_disp | input | 32 | Outer displacement |
| odisp_long | input | 1 | 1: full 32-bit outer displacement, 0: sign-extended low 16 bits |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer read address |
| mem_rdy | input | 1 | Read data valid this cycle |
| mem_data | input | 32 | Fetched pointer |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle strobe: `ea` is valid |
| ea | output | 32 | Final effective address |

## Verification
An indexed result is due at the first sampling point after the start edge. A pre- or post-indexed result is due 3 + W cycles after it, where W is the number of wait cycles the bench memory model inserts before raising `mem_rdy`. The bench drives inputs and samples outputs on the falling edge, counts falling edges from the start until `done`, and compares that count with the due cycle as well as the value of `ea`. While a request is pending it also checks that the read address is the expected intermediate sum and that it stays unchanged.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        MODE_INDEX   = 2'd0,
        MODE_PRE_IND = 2'd1,
        MODE_POST_IND = 2'd2,
        MODE_INDEX_ALT = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_FETCH = 2'd2,
        ST_DONE  = 2'd3
    } ea_state_e;

    typedef struct packed {
        ea_state_e         st;
        ea_mode_e          mode;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] sidx;
        logic [ADDR_W-1:0] outer;
        logic [ADDR_W-1:0] result;
    } ea_regs_t;

    function automatic logic is_indirect(input ea_mode_e m);
        return (m == MODE_PRE_IND) || (m == MODE_POST_IND);
    endfunction

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int W       = 32,
    parameter int SHORT_W = 16
) (
    input  logic [W-1:0] disp_in,
    input  logic         long_sel,
    output logic [W-1:0] disp_out
);
    localparam int EXT_W = W - SHORT_W;

    logic [W-1:0] short_x;

    // replicate the sign bit of the short form across the upper part
    assign short_x  = {{EXT_W{disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};
    assign disp_out = long_sel ? disp_in : short_x;
endmodule

// File: rtl/ea_scaler.sv
module ea_scaler #(
    parameter int W       = 32,
    parameter int SCALE_W = 2
) (
    input  logic [W-1:0]       idx_in,
    input  logic [SCALE_W-1:0] scale_sel,
    input  logic               suppress,
    output logic [W-1:0]       idx_out
);
    localparam int N_FACT = 1 << SCALE_W;

    logic [W-1:0] shifted [N_FACT];

    for (genvar g = 0; g < N_FACT; g++) begin : g_shift
        assign shifted[g] = idx_in << g;
    end

    assign idx_out = suppress ? '0 : shifted[scale_sel];
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] term_a,
    input  logic [W-1:0] term_b,
    input  logic [W-1:0] term_c,
    output logic [W-1:0] sum
);
    // modulo-2^W sum, carries past the top bit are dropped
    assign sum = term_a + term_b + term_c;
endmodule

// File: rtl/ea_indirect_gen.sv
module ea_indirect_gen
    import ea_pkg::*;
#(
    parameter int SHORT_W = 16,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               base_sup,
    input  logic [ADDR_W-1:0]  base_disp,
    input  logic               bdisp_long,
    input  logic [ADDR_W-1:0]  idx_val,
    input  logic               idx_sup,
    input  logic [SCALE_W-1:0] scale,
    input  logic [ADDR_W-1:0]  outer_disp,
    input  logic               odisp_long,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rdy,
    input  logic [ADDR_W-1:0]  mem_data,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  ea
);

    ea_regs_t r_d, r_q;

    ea_mode_e          live_mode;
    logic [ADDR_W-1:0] base_t;
    logic [ADDR_W-1:0] bdisp_x;
    logic [ADDR_W-1:0] odisp_x;
    logic [ADDR_W-1:0] sidx;
    logic [ADDR_W-1:0] pre_term;
    logic [ADDR_W-1:0] sum_first;
    logic [ADDR_W-1:0] post_term;
    logic [ADDR_W-1:0] sum_final;

    assign live_mode = ea_mode_e'(mode);
    assign base_t    = base_sup ? '0 : base_val;

    ea_disp_ext #(.W(ADDR_W), .SHORT_W(SHORT_W)) u_bdisp (
        .disp_in  (base_disp),
        .long_sel (bdisp_long),
        .disp_out (bdisp_x)
    );

    ea_disp_ext #(.W(ADDR_W), .SHORT_W(SHORT_W)) u_odisp (
        .disp_in  (outer_disp),
        .long_sel (odisp_long),
        .disp_out (odisp_x)
    );

    ea_scaler #(.W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
        .idx_in    (idx_val),
        .scale_sel (scale),
        .suppress  (idx_sup),
        .idx_out   (sidx)
    );

    // first sum: the index joins here unless it is applied after the fetch
    assign pre_term = (live_mode == MODE_POST_IND) ? '0 : sidx;

    ea_adder3 #(.W(ADDR_W)) u_sum_first (
        .term_a (base_t),
        .term_b (bdisp_x),
        .term_c (pre_term),
        .sum    (sum_first)
    );

    // second sum: fetched pointer plus outer displacement plus late index
    assign post_term = (r_q.mode == MODE_POST_IND) ? r_q.sidx : '0;

    ea_adder3 #(.W(ADDR_W)) u_sum_final (
        .term_a (mem_data),
        .term_b (r_q.outer),
        .term_c (post_term),
        .sum    (sum_final)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.mode  = live_mode;
                    r_d.sidx  = sidx;
                    r_d.outer = odisp_x;
                    if (is_indirect(live_mode)) begin
                        r_d.addr = sum_first;
                        r_d.st   = ST_CALC;
                    end else begin
                        r_d.result = sum_first;
                        r_d.st     = ST_DONE;
                    end
                end
            end
            ST_CALC: begin
                r_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_rdy) begin
                    r_d.result = sum_final;
                    r_d.st     = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = (r_q.st == ST_FETCH);
    assign mem_addr = r_q.addr;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = (r_q.st == ST_DONE);
    assign ea       = r_q.result;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr))); // R8

    AST_INDEX_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (mode == 2'd0 || mode == 2'd3)) |=> (done && !mem_req)); // R2

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9

    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rdy) |=> (done && !mem_req)); // R8

endmodule

// File: tb/ea_indirect_gen_test.sv
module ea_indirect_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [31:0] base_val = '0, base_disp = '0, idx_val = '0, outer_disp = '0;
    logic        base_sup = 1'b0, bdisp_long = 1'b0, idx_sup = 1'b0, odisp_long = 1'b0;
    logic [1:0]  scale = '0;
    logic        mem_req, mem_rdy, busy, done;
    logic [31:0] mem_addr, mem_data, ea;

    int checks = 0;
    int errors = 0;
    int wait_cyc = 0;
    int req_cnt = 0;

    always #2.5 clk = ~clk;

    ea_indirect_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base_val(base_val), .base_sup(base_sup), .base_disp(base_disp),
        .bdisp_long(bdisp_long), .idx_val(idx_val), .idx_sup(idx_sup),
        .scale(scale), .outer_disp(outer_disp), .odisp_long(odisp_long),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
        .mem_data(mem_data), .busy(busy), .done(done), .ea(ea)
    );

    // memory model: pointer is a fixed scramble of the address
    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
    endfunction

    assign mem_data = mem_fn(mem_addr);
    assign mem_rdy  = mem_req && (req_cnt > wait_cyc);

    always @(negedge clk) begin
        if (mem_req) req_cnt <= req_cnt + 1;
        else         req_cnt <= 0;
    end

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] b;
        logic        bs;
        logic [31:0] d;
        logic        dl;
        logic [31:0] x;
        logic        xs;
        logic [1:0]  sc;
        logic [31:0] o;
        logic        ol;
        logic [3:0]  w;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_1000, 1'b0, 32'h0000_0010, 1'b0, 32'h0000_0003, 1'b0, 2'd0, 32'h0, 1'b0, 4'd0},
        '{2'd0, 32'h0001_0000, 1'b0, 32'h0000_FFF0, 1'b0, 32'h0000_0005, 1'b0, 2'd3, 32'h0, 1'b0, 4'd0},
        '{2'd3, 32'h8000_0000, 1'b0, 32'h1234_8000, 1'b1, 32'h0000_0100, 1'b0, 2'd2, 32'h0, 1'b0, 4'd0},
        '{2'd0, 32'hDEAD_BEEF, 1'b1, 32'h0000_0004, 1'b0, 32'h0000_0007, 1'b1, 2'd1, 32'h0, 1'b0, 4'd0},
        '{2'd1, 32'h0002_0000, 1'b0, 32'h0000_0100, 1'b0, 32'h0000_0010, 1'b0, 2'd2, 32'h0000_0020, 1'b0, 4'd0},
        '{2'd1, 32'h0004_0000, 1'b0, 32'h0000_FF00, 1'b0, 32'h0000_0001, 1'b0, 2'd1, 32'h0000_8000, 1'b0, 4'd2},
        '{2'd2, 32'h0003_0000, 1'b0, 32'h0000_0040, 1'b0, 32'h0000_0009, 1'b0, 2'd3, 32'h1000_0000, 1'b1, 4'd0},
        '{2'd2, 32'h0005_5550, 1'b0, 32'hFFFF_FFFC, 1'b1, 32'h0000_0002, 1'b0, 2'd0, 32'h0000_7FFF, 1'b0, 4'd3},
        '{2'd2, 32'h1111_1111, 1'b1, 32'h0000_0200, 1'b0, 32'h0000_0044, 1'b1, 2'd2, 32'h0000_0001, 1'b0, 4'd1},
        '{2'd1, 32'h0006_0000, 1'b1, 32'h0007_0000, 1'b1, 32'h0000_0008, 1'b0, 2'd3, 32'h0000_0000, 1'b0, 4'd0}
    };

    function automatic logic [31:0] sx(input logic [31:0] v, input logic lng);
        return lng ? v : {{16{v[15]}}, v[15:0]};
    endfunction

    function automatic logic [31:0] scaled(input vec_t v);
        logic [31:0] f;
        case (v.sc)
            2'd0: f = 32'd1;
            2'd1: f = 32'd2;
            2'd2: f = 32'd4;
            default: f = 32'd8;
        endcase
        return v.xs ? 32'd0 : v.x * f;
    endfunction

    function automatic logic [31:0] exp_addr(input vec_t v);
        logic [31:0] s;
        s = (v.bs ? 32'd0 : v.b) + sx(v.d, v.dl);
        if (v.md != 2'd2) s = s + scaled(v);
        return s;
    endfunction

    function automatic logic [31:0] exp_ea(input vec_t v);
        logic [31:0] p;
        if (v.md == 2'd0 || v.md == 2'd3) return exp_addr(v);
        p = mem_fn(exp_addr(v)) + sx(v.o, v.ol);
        if (v.md == 2'd2) p = p + scaled(v);
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode = v.md; base_val = v.b; base_sup = v.bs; base_disp = v.d;
        bdisp_long = v.dl; idx_val = v.x; idx_sup = v.xs; scale = v.sc;
        outer_disp = v.o; odisp_long = v.ol;
    endtask

    // called at a falling edge with the block idle
    task automatic run_op(input vec_t v, input bit hammer, input string tag);
        int n;
        bit got_req;
        logic [31:0] cap;
        bit indirect;
        indirect = (v.md == 2'd1 || v.md == 2'd2);
        wait_cyc = int'(v.w);
        apply(v);
        start = 1'b1;
        n = 0; got_req = 1'b0; cap = '0;
        do begin
            @(negedge clk);
            n++;
            if (hammer) begin
                start = 1'b1; mode = ~mode; base_val = ~base_val;
                idx_val = idx_val + 32'd77; outer_disp = 32'h0BAD_0000;
            end else begin
                start = 1'b0;
            end
            if (mem_req) begin
                if (!got_req) begin
                    cap = mem_addr;
                    check({tag, " R5/R6 read address"}, mem_addr, exp_addr(v));
                end else begin
                    check({tag, " R8 address held"}, mem_addr, cap);
                end
                got_req = 1'b1;
            end
        end while (!done && n < 40);
        start = 1'b0;
        check({tag, " ea value"}, ea, exp_ea(v));
        check({tag, indirect ? " R8 latency" : " R2 latency"},
              32'(n), indirect ? 32'(3 + v.w) : 32'd1);
        check({tag, " R2/R8 request use"}, {31'd0, got_req}, {31'd0, indirect});
        @(negedge clk);
        check({tag, " R10 done single cycle"}, {31'd0, done}, 32'd0);
        check({tag, " R10 back to idle"}, {31'd0, busy}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 done in reset", {31'd0, done}, 32'd0);
        check("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);

        // table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], 1'b0, $sformatf("vec%0d R2-7", i));
        end

        // R3: every scale code on an indexed op
        for (int s = 0; s < 4; s++) begin
            vec_t v;
            v = '{2'd0, 32'h100, 1'b0, 32'h0, 1'b0, 32'h0000_0011, 1'b0, 2'(s), 32'h0, 1'b0, 4'd0};
            run_op(v, 1'b0, $sformatf("R3 scale%0d", s));
        end

        // R4: negative short outer displacement on pre-indexed fetch
        begin
            vec_t v;
            v = '{2'd1, 32'h0000_2000, 1'b0, 32'h0000_8001, 1'b0, 32'h0, 1'b1, 2'd0, 32'hABCD_FFFF, 1'b0, 4'd1};
            run_op(v, 1'b0, "R4 short negatives");
        end

        // R9: start held high with changing operands while busy
        run_op(VECS[6], 1'b1, "R9 indirect busy");
        run_op(VECS[1], 1'b1, "R9 indexed busy");

        // R9: no further done after a hammered run once start is low
        repeat (3) begin
            @(negedge clk);
            check("R9 no second done", {31'd0, done}, 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule